// File: doc/BRIEF.md
# Priority Matched-Pattern Readout

This block turns the per-pattern match flags of an associative pattern bank into a serial stream of pattern addresses, one address per clock cycle. On every transfer slot it selects the highest-numbered pattern that is matched and not yet reported. It presents that index with a valid strobe and marks the pattern in a kill vector, so the pattern is never reported again within the same event.

Readout runs while the bank is still collecting hits. A flag that rises in the middle of a readout joins the remaining unread flags and is ordered by priority among them. A downstream not-ready condition freezes the presented address and the kill vector. An end-of-event pulse clears all kill state so the next event starts fresh. A `drained` output reports that nothing is left to read.

Top module: `match_readout`

## Requirements
- R1: After reset, `addrValid` is 0 and every bit of `killVec` is 0.
- R2: When several unread flags are set, the address presented is the largest index among them. The stream is in strictly decreasing index order for flags that are present together.
- R3: The bit `killVec[i]` is 1 whenever address i is presented. A pattern whose flag stays set after it has been presented is never presented again before the next end-of-event pulse.
- R4: While `addrValid` is 1 and `outReady` is 0, `addrOut`, `addrValid` and `killVec` keep their values on the next cycle.
- R5: A cycle with `eventEnd` at 1 makes `addrValid` 0 and `killVec` all zeros on the following cycle. This takes priority over loading a new address.
- R6: A flag that rises while lower-indexed flags are still unread is presented before those lower ones, as soon as the next transfer slot opens.
- R7: `drained` is 1 exactly when `addrValid` is 0 and every set match flag already has its kill bit set.
- R8: With the output slot empty, a flag that is set before a clock edge is presented with `addrValid` at 1 right after that edge. With `outReady` at 1, one address is transferred per cycle.
- R9: At most one bit of `killVec` changes from 0 to 1 per cycle. The bit that rises is the index being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| matchFlags | input | NUM_PATTERNS | Pattern-match flags from the bank, bit i for pattern i |
| eventEnd | input | 1 | One-cycle end-of-event pulse; clears all kill state |
| outReady | input | 1 | Downstream accepts the presented address this cycle |
| addrOut | output | ADDR_W | Index of the presented pattern |
| addrValid | output | 1 | `addrOut` holds a pattern to transfer |
| killVec | output | NUM_PATTERNS | Patterns already read out in this event |
| drained | output | 1 | No output pending and no unread match left |

## Verification
The bound checker covers the properties that hold on every cycle:
- the stall hold;
- the presence of the presented index in the kill vector;
- the single new kill bit per cycle;
- the clearing effect of the end-of-event pulse;
- the rule that every freshly loaded address was the highest unread flag one cycle earlier.

Only the bench scenarios can show the whole-event properties. These are the exact address order, including a late high flag overtaking queued lower ones, the absence of repeated reports while flags stay set, and the one-cycle latency from a flag to a valid address.

// File: rtl/readout_pkg.sv
package readout_pkg;

  // Strobes the control unit sends to the datapath each cycle.
  typedef struct packed {
    logic load;    // capture the highest unread index and kill it
    logic retire;  // transfer done with nothing to follow: drop valid
    logic clear;   // end of event: wipe kill state and output
  } ctrl_strobes_t;

endpackage

// File: rtl/highest_set_encoder.sv
module highest_set_encoder #(
  parameter int WIDTH   = 64,
  parameter int GROUP_W = 8,
  localparam int ADDR_W = $clog2(WIDTH),
  localparam int LOC_W  = $clog2(GROUP_W),
  localparam int GROUPS = WIDTH / GROUP_W
) (
  input  logic [WIDTH-1:0]  vecIn,
  output logic [ADDR_W-1:0] topIdx,
  output logic              anySet
);

  logic [GROUPS-1:0] grpAny;
  logic [LOC_W-1:0]  grpIdx [GROUPS];

  // First level: each group finds its own highest set bit in parallel.
  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic [GROUP_W-1:0] slice;
    assign slice = vecIn[g*GROUP_W +: GROUP_W];

    always_comb begin
      grpIdx[g] = '0;
      for (int b = 0; b < GROUP_W; b++) begin
        if (slice[b]) grpIdx[g] = LOC_W'(b);
      end
    end

    assign grpAny[g] = |slice;
  end

  // Second level: the highest non-empty group wins.
  always_comb begin
    topIdx = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grpAny[g]) topIdx = ADDR_W'(g * GROUP_W) + ADDR_W'(grpIdx[g]);
    end
  end

  assign anySet = |grpAny;

endmodule

// File: rtl/readout_control.sv
module readout_control
  import readout_pkg::*;
(
  input  logic          addrValid,
  input  logic          outReady,
  input  logic          eventEnd,
  input  logic          anyPending,
  output ctrl_strobes_t strobes
);

  logic slotOpen;

  // The output register may take a new value when it is empty or being
  // transferred this cycle.
  assign slotOpen = !addrValid || outReady;

  always_comb begin
    strobes = '0;
    if (eventEnd) begin
      strobes.clear = 1'b1;
    end else if (slotOpen) begin
      if (anyPending) strobes.load   = 1'b1;
      else            strobes.retire = 1'b1;
    end
  end

endmodule

// File: rtl/readout_datapath.sv
module readout_datapath
  import readout_pkg::*;
#(
  parameter int NUM_PATTERNS = 64,
  parameter int GROUP_W      = 8,
  localparam int ADDR_W = $clog2(NUM_PATTERNS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PATTERNS-1:0] matchFlags,
  input  ctrl_strobes_t           strobes,
  output logic [ADDR_W-1:0]       addrOut,
  output logic                    addrValid,
  output logic [NUM_PATTERNS-1:0] killVec,
  output logic                    anyPending
);

  logic [NUM_PATTERNS-1:0] killQ;
  logic [NUM_PATTERNS-1:0] pendingVec;
  logic [ADDR_W-1:0]       nextIdx;
  logic [ADDR_W-1:0]       addrQ;
  logic                    validQ;

  // Unread matches: set in the bank and not yet reported.
  assign pendingVec = matchFlags & ~killQ;

  highest_set_encoder #(
    .WIDTH  (NUM_PATTERNS),
    .GROUP_W(GROUP_W)
  ) uEnc (
    .vecIn (pendingVec),
    .topIdx(nextIdx),
    .anySet(anyPending)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      killQ  <= '0;
      addrQ  <= '0;
      validQ <= 1'b0;
    end else if (strobes.clear) begin
      killQ  <= '0;
      validQ <= 1'b0;
    end else if (strobes.load) begin
      killQ[nextIdx] <= 1'b1;
      addrQ          <= nextIdx;
      validQ         <= 1'b1;
    end else if (strobes.retire) begin
      validQ <= 1'b0;
    end
  end

  assign addrOut   = addrQ;
  assign addrValid = validQ;
  assign killVec   = killQ;

endmodule

// File: rtl/match_readout.sv
module match_readout
  import readout_pkg::*;
#(
  parameter int NUM_PATTERNS = 64,
  parameter int GROUP_W      = 8,
  localparam int ADDR_W = $clog2(NUM_PATTERNS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PATTERNS-1:0] matchFlags,
  input  logic                    eventEnd,
  input  logic                    outReady,
  output logic [ADDR_W-1:0]       addrOut,
  output logic                    addrValid,
  output logic [NUM_PATTERNS-1:0] killVec,
  output logic                    drained
);

  ctrl_strobes_t strobes;
  logic          anyPending;

  readout_control uCtrl (
    .addrValid (addrValid),
    .outReady  (outReady),
    .eventEnd  (eventEnd),
    .anyPending(anyPending),
    .strobes   (strobes)
  );

  readout_datapath #(
    .NUM_PATTERNS(NUM_PATTERNS),
    .GROUP_W     (GROUP_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .matchFlags(matchFlags),
    .strobes   (strobes),
    .addrOut   (addrOut),
    .addrValid (addrValid),
    .killVec   (killVec),
    .anyPending(anyPending)
  );

  assign drained = !addrValid && !anyPending;

endmodule

// File: rtl/match_readout_checker.sv
module match_readout_checker #(
  parameter int NUM_PATTERNS = 64,
  localparam int ADDR_W = $clog2(NUM_PATTERNS)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_PATTERNS-1:0] matchFlags,
  input logic                    eventEnd,
  input logic                    outReady,
  input logic [ADDR_W-1:0]       addrOut,
  input logic                    addrValid,
  input logic [NUM_PATTERNS-1:0] killVec,
  input logic                    drained
);

  logic [NUM_PATTERNS-1:0] pendPrev;
  logic                    loadPrev;

  // Port-level view of the previous cycle: unread flags and whether a new
  // address had to be taken.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPrev <= '0;
      loadPrev <= 1'b0;
    end else begin
      pendPrev <= matchFlags & ~killVec;
      loadPrev <= (!addrValid || outReady) && !eventEnd && (|(matchFlags & ~killVec));
    end
  end

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !outReady && !eventEnd |=> addrValid && $stable(addrOut) && $stable(killVec));

  assert_presented_killed_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> killVec[addrOut]);

  assert_event_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    eventEnd |=> !addrValid && (killVec == '0));

  assert_one_kill_per_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(killVec & ~$past(killVec)) <= 1);

  assert_highest_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadPrev |-> addrValid && ((pendPrev >> addrOut) == NUM_PATTERNS'(1)));

  assert_drained_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    drained |-> !addrValid);

endmodule

bind match_readout match_readout_checker #(.NUM_PATTERNS(NUM_PATTERNS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .matchFlags(matchFlags),
  .eventEnd  (eventEnd),
  .outReady  (outReady),
  .addrOut   (addrOut),
  .addrValid (addrValid),
  .killVec   (killVec),
  .drained   (drained)
);

// File: tb/tb_match_readout.sv
`timescale 1ns/1ps
module tb_match_readout;

  localparam int N  = 64;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  matchFlags;
  logic          eventEnd;
  logic          outReady;
  logic [AW-1:0] addrOut;
  logic          addrValid;
  logic [N-1:0]  killVec;
  logic          drained;

  int totalChecks = 0;
  int badChecks   = 0;
  int expQ[$];
  int cycles = 0;

  always #2 clk = ~clk;

  match_readout #(.NUM_PATTERNS(N)) dut (
    .clk(clk), .rstN(rstN), .matchFlags(matchFlags), .eventEnd(eventEnd),
    .outReady(outReady), .addrOut(addrOut), .addrValid(addrValid),
    .killVec(killVec), .drained(drained)
  );

  task automatic checkEq(string req, logic [63:0] act, logic [63:0] exp);
    totalChecks++;
    if (act !== exp) begin
      badChecks++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepDrive();
    @(posedge clk);
    #1;
  endtask

  task automatic pushExp(int a);
    expQ.push_back(a);
  endtask

  task automatic endEvent();
    stepDrive();
    matchFlags = '0;
    eventEnd   = 1'b1;
    stepDrive();
    eventEnd = 1'b0;
  endtask

  // Monitor: every transfer is compared with the head of the queue.
  always @(negedge clk) begin
    if (rstN && addrValid && outReady) begin
      if (expQ.size() == 0) begin
        checkEq("R2 unexpected address", 64'(addrOut), 64'hFFFF);
      end else begin
        checkEq("R2 order", 64'(addrOut), 64'(expQ.pop_front()));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      badChecks++;
      totalChecks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; matchFlags = '0; eventEnd = 1'b0; outReady = 1'b1;
    repeat (3) stepDrive();
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 valid after reset", 64'(addrValid), 0);
    checkEq("R1 kill after reset", killVec, 0);
    checkEq("R7 drained idle", 64'(drained), 1);

    // R8 / R2: boundary indices present together.
    stepDrive();
    pushExp(63); pushExp(40); pushExp(17); pushExp(0);
    matchFlags = (64'd1 << 63) | (64'd1 << 40) | (64'd1 << 17) | 64'd1;
    @(posedge clk); @(negedge clk);
    checkEq("R8 one-cycle latency", 64'(addrValid), 1);
    checkEq("R8 first address", 64'(addrOut), 63);
    checkEq("R9 single kill bit", killVec, 64'd1 << 63);
    repeat (5) @(negedge clk);
    checkEq("R7 drained after readout", 64'(drained), 1);
    checkEq("R3 kill covers all read", killVec, matchFlags);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checkEq("R3 no repeat while flags held", 64'(addrValid), 0);
    end
    endEvent();
    @(negedge clk);
    checkEq("R5 kill cleared", killVec, 0);

    // R6: a late higher flag overtakes queued lower ones.
    stepDrive();
    pushExp(10); pushExp(40); pushExp(3); pushExp(1);
    matchFlags = (64'd1 << 10) | (64'd1 << 3) | (64'd1 << 1);
    stepDrive();
    matchFlags[40] = 1'b1;
    repeat (6) @(negedge clk);
    checkEq("R6 all drained", 64'(drained), 1);
    endEvent();

    // R4: stall holds address and kill vector.
    stepDrive();
    outReady = 1'b0;
    pushExp(5); pushExp(2);
    matchFlags = (64'd1 << 5) | (64'd1 << 2);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checkEq("R4 valid held", 64'(addrValid), 1);
      checkEq("R4 address held", 64'(addrOut), 5);
      checkEq("R4 kill held", killVec, 64'd1 << 5);
      @(negedge clk);
    end
    stepDrive();
    outReady = 1'b1;
    repeat (4) @(negedge clk);
    endEvent();

    // R5: end of event while an address waits.
    stepDrive();
    outReady   = 1'b0;
    matchFlags = (64'd1 << 7) | (64'd1 << 4);
    repeat (2) @(negedge clk);
    checkEq("R5 pre valid", 64'(addrValid), 1);
    checkEq("R5 pre address", 64'(addrOut), 7);
    stepDrive();
    matchFlags = '0;
    eventEnd   = 1'b1;
    @(posedge clk); @(negedge clk);
    checkEq("R5 valid dropped", 64'(addrValid), 0);
    checkEq("R5 kill wiped", killVec, 0);
    checkEq("R7 drained after clear", 64'(drained), 1);
    stepDrive();
    eventEnd = 1'b0;
    outReady = 1'b1;
    repeat (3) @(negedge clk);

    checkEq("R2 queue empty", 64'(expQ.size()), 0);
    $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule